// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Aggregator

This block gathers the fourteen event sources of a serial port into one interrupt line. Each source delivers a one-cycle pulse, and that pulse sets a sticky bit in a status register whether or not the source is enabled. A separate mask selects which sources may raise the interrupt. Software never writes the mask directly. It writes ones to a set register to enable sources and ones to a clear register to disable them. Two agents can therefore change different bits without a read-modify-write race.

The interrupt output is high while any source is both enabled and pending. Software reads the status register, handles the sources it finds, and writes ones back to the status register to acknowledge them. The register port is a plain strobe: one address is used for the write and for the combinational read data, and a write takes effect on the clock edge where the write enable is high.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask reads 0, the status reads 0 and `irq` is 0, so every source starts disabled.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1. Mask bits written with 0 keep their value. The new mask is readable on the next cycle.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1. Other mask bits keep their value. Writing 0x3FFF disables every source.
- R4: The mask is read at offset 0x10. A write to 0x10, or to any unmapped offset, changes neither the mask nor the status.
- R5: A 1 on `events[i]` in a cycle sets status bit i at that clock edge, whatever the mask holds. The bit stays set until it is acknowledged. Status is read at offset 0x14. The bit order from 0 to 13 is: receive level, receive empty, receive full, transmit empty, transmit full, receive overrun, framing error, parity error, receive idle timeout, line status change, transmit level, transmit almost full, transmit overflow, receive break.
- R6: A write to offset 0x14 clears each status bit whose write-data bit is 1. Bits written with 0 are not affected.
- R7: If an event pulse and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when the bitwise AND of mask and status is nonzero. It follows the registers in the same cycle they update.
- R9: Read data bits 31 to 14 are always 0. Write-data bits 31 to 14 have no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Register offset for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| events | input | 14 | One-cycle event pulses, one per source |
| irq | output | 1 | Interrupt request |

## Verification
A wrong mask bit shows in two places: in the readback at offset 0x10 on the cycle after the write, and in `irq`, which differs as soon as the matching status bit is pending. A status bit that is lost, or cleared by the wrong write, shows at offset 0x14 one cycle after the event or acknowledge. The full grid of single mask bit against single pending bit also catches a crossed bit position: `irq` rises for the wrong pair, or stays low for the right one, in the cycle after the pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic clrStatus;
  } irqc_strb_t;

  // Event bit positions: the event producers drive these lines
  localparam int unsigned EV_RX_LEVEL       = 0;
  localparam int unsigned EV_RX_EMPTY       = 1;
  localparam int unsigned EV_RX_FULL        = 2;
  localparam int unsigned EV_TX_EMPTY       = 3;
  localparam int unsigned EV_TX_FULL        = 4;
  localparam int unsigned EV_RX_OVERRUN     = 5;
  localparam int unsigned EV_FRAME_ERR      = 6;
  localparam int unsigned EV_PARITY_ERR     = 7;
  localparam int unsigned EV_RX_IDLE        = 8;
  localparam int unsigned EV_LINE_CHANGE    = 9;
  localparam int unsigned EV_TX_LEVEL       = 10;
  localparam int unsigned EV_TX_ALMOST_FULL = 11;
  localparam int unsigned EV_TX_OVERFLOW    = 12;
  localparam int unsigned EV_RX_BREAK       = 13;
  localparam int unsigned EV_COUNT          = 14;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 14,
  parameter logic [ADDR_W-1:0] SET_OFS  = 'h08,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_SRC-1:0] statusQ,
  output irqc_strb_t         strb,
  output logic [NUM_SRC-1:0] wBits,
  output logic [DATA_W-1:0]  rdData
);

  // Only the valid source bits of the write data reach the datapath
  assign wBits = wrData[NUM_SRC-1:0];

  // Write decode
  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (addr == SET_OFS)  strb.setMask   = 1'b1;
      if (addr == CLR_OFS)  strb.clrMask   = 1'b1;
      if (addr == STAT_OFS) strb.clrStatus = 1'b1;
    end
  end

  // Read mux with zero padding above the valid bits
  always_comb begin
    if (addr == MASK_OFS)      rdData = DATA_W'(maskQ);
    else if (addr == STAT_OFS) rdData = DATA_W'(statusQ);
    else                       rdData = '0;
  end

  // R9
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_SRC] == '0);

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setMask, strb.clrMask, strb.clrStatus}));

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqc_strb_t         strb,
  input  logic [NUM_SRC-1:0] wBits,
  input  logic [NUM_SRC-1:0] events,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               irq
);

  logic [NUM_SRC-1:0] maskNxt;
  logic [NUM_SRC-1:0] statusNxt;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    // Clear wins over set on the mask
    assign maskNxt[b] = (strb.clrMask && wBits[b]) ? 1'b0 :
                        (strb.setMask && wBits[b]) ? 1'b1 : maskQ[b];
    // A new event wins over an acknowledge on the status
    assign statusNxt[b] = events[b] ? 1'b1 :
                          (strb.clrStatus && wBits[b]) ? 1'b0 : statusQ[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      maskQ   <= maskNxt;
      statusQ <= statusNxt;
    end
  end

  assign irq = |(maskQ & statusQ);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask && !strb.clrMask) |=> ((maskQ & $past(wBits)) == $past(wBits)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask |=> ((maskQ & $past(wBits)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setMask && !strb.clrMask) |=> $stable(maskQ));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R5
  status_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (events != '0) |=> ((statusQ & $past(events)) == $past(events)));

  // R6
  status_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && events == '0) |=> ((statusQ & $past(wBits)) == '0));

  // R7
  event_beats_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && (events & wBits) != '0) |=> ((statusQ & $past(events & wBits)) != '0));

  // R8
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0 || statusQ == '0) |-> !irq);

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = EV_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] events,
  output logic               irq
);

  irqc_strb_t         strb;
  logic [NUM_SRC-1:0] wBits;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statusQ;

  irqc_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .maskQ  (maskQ),
    .statusQ(statusQ),
    .strb   (strb),
    .wBits  (wBits),
    .rdData (rdData)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wBits  (wBits),
    .events (events),
    .maskQ  (maskQ),
    .statusQ(statusQ),
    .irq    (irq)
  );

endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [13:0] events = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [13:0] expM = '0;
  logic [13:0] expS = '0;

  always #5 clk = ~clk;

  irq_mask_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .events(events), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the edge took effect
  task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [13:0] ev);
    wrEn = we; addr = a; wrData = d; events = ev;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0; events = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0);
    if (a == 8'h08) expM = expM | d[13:0];
    if (a == 8'h0C) expM = expM & ~d[13:0];
    if (a == 8'h14) expS = expS & ~d[13:0];
  endtask

  task automatic pulse(input logic [13:0] ev);
    drive(1'b0, '0, '0, ev);
    expS = expS | ev;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
    addr = '0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    rd(8'h10, v);
    chk({req, " mask"}, v, {18'h0, expM});
    rd(8'h14, v);
    chk({req, " status"}, v, {18'h0, expS});
    #1;
    chk({req, " irq"}, {31'h0, irq}, {31'h0, |(expM & expS)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R2: accumulate enables one bit at a time
    for (int i = 0; i < 14; i++) begin
      wr(8'h08, 32'h1 << i);
      checkAll("R2 set one bit");
    end
    // R3: remove them in reverse order
    for (int i = 13; i >= 0; i--) begin
      wr(8'h0C, 32'h1 << i);
      checkAll("R3 clear one bit");
    end
    wr(8'h08, 32'h0000_3C3C);
    wr(8'h08, 32'h0000_0101);
    checkAll("R2 set keeps others");
    wr(8'h0C, 32'h0000_3FFF);
    chk("R3 disable all", {18'h0, expM}, 32'h0);
    checkAll("R3 disable all");

    // R4: writes to the mask offset and an unmapped offset are ignored
    wr(8'h08, 32'h0000_00A5);
    wr(8'h10, 32'hFFFF_FFFF);
    checkAll("R4 write to mask offset");
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    checkAll("R4 write unmapped");

    // R9: upper write bits dropped, upper read bits zero, unmapped reads zero
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, v);
    chk("R9 mask upper bits", v, 32'h0000_3FFF);
    rd(8'h00, v);
    chk("R9 unmapped read", v, 32'h0);
    rd(8'h0C, v);
    chk("R9 write-only read", v, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R5: events latch with mask all zero, irq stays low (R8)
    for (int i = 0; i < 14; i++) begin
      pulse(14'h1 << i);
      checkAll("R5 latch unmasked");
    end
    chk("R5 all latched", {18'h0, expS}, 32'h3FFF);

    // R6: partial acknowledge
    wr(8'h14, 32'hFFFF_5555);
    checkAll("R6 ack pattern");
    chk("R6 remaining", {18'h0, expS}, 32'h2AAA);
    wr(8'h14, 32'h0000_0000);
    checkAll("R6 ack zero no effect");
    wr(8'h14, 32'h0000_3FFF);
    checkAll("R6 ack all");

    // R7: event and acknowledge on the same bit in the same cycle
    pulse(14'h0018);
    drive(1'b1, 8'h14, 32'h0000_0018, 14'h0008);
    expS = 14'h0008;
    checkAll("R7 event beats ack");
    rd(8'h14, v);
    chk("R7 status", v, 32'h0000_0008);
    wr(8'h14, 32'h0000_3FFF);

    // R8: every single mask bit against every single pending bit
    for (int i = 0; i < 14; i++) begin
      for (int j = 0; j < 14; j++) begin
        wr(8'h0C, 32'h3FFF);
        wr(8'h14, 32'h3FFF);
        wr(8'h08, 32'h1 << i);
        pulse(14'h1 << j);
        #1;
        chk($sformatf("R8 mask bit %0d pending bit %0d", i, j),
            {31'h0, irq}, {31'h0, (i == j)});
        // Dropping the mask bit removes the request while status stays set
        if (i == j) begin
          wr(8'h0C, 32'h1 << i);
          #1;
          chk("R8 irq drops with mask", {31'h0, irq}, 32'h0);
        end
      end
    end

    // R8: a set mask bit raises irq as soon as its event arrives
    wr(8'h14, 32'h3FFF);
    wr(8'h08, 32'h0000_2001);
    pulse(14'h2000);
    checkAll("R8 break source");
    wr(8'h14, 32'h2000);
    checkAll("R8 ack lowers irq");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule